// File: doc/BRIEF.md
# Validation Coprocessor with Timed Interrupts

This block is a test-support coprocessor that sits beside a CPU core in a verification build. It holds sixteen 32-bit general registers. The CPU reads and writes them with register transfers, and it starts data operations by presenting an instruction word together with a one-cycle start strobe. The block answers each operation on a busy/done/cant handshake.

Three services are offered. A busy wait holds the CPU for a programmed number of cycles. An interrupt injector drives the active-low fast or normal interrupt request low, either at once or after a programmed delay, and a matching release drives it high again. A time-stamp operation copies a free-running 32-bit cycle counter into a register, so software can measure elapsed time.

The operation code sits in instruction bits 23:20. The delay operand is the register selected by bits 3:0. Register transfers select their register with bits 19:16. The cycle counter wraps, and the end-of-wait comparison is made on the wrapped difference, so a wait that crosses the wrap point still ends on time.

Top module: `valid_coproc`

## Requirements
- R1: After reset, fiq_n and irq_n are high, cp_busy, cp_done and cp_cant are low, and all sixteen registers read zero.
- R2: A transfer write with xfer_wr high stores xfer_wdata into the register indexed by xfer_instr bits 19:16 at the next clock edge. xfer_rdata shows, without a clock, the register indexed by those same bits.
- R3: Opcode 0 (instruction bits 23:20) with a zero delay operand gives a one-cycle cp_done in the cycle after the start edge, and cp_busy is never raised.
- R4: Opcode 0 with delay operand d > 0 (the register indexed by instruction bits 3:0) holds cp_busy for exactly d cycles after the start edge, then gives a one-cycle cp_done. The end test uses the wrapped counter difference.
- R5: Opcode 1 with delay d drives fiq_n low at the d-th clock edge after the start edge. With d = 0 that is the start edge itself. fiq_n then stays low until released.
- R6: Opcode 2 does the same for irq_n, and neither injector touches the other line.
- R7: Opcode 3 drives fiq_n high and opcode 4 drives irq_n high, both at the start edge.
- R8: Opcode 5 writes the cycle counter value at the start edge into the register indexed by bits 3:0. Two captures taken k edges apart differ by k.
- R9: Opcodes 6 to 15 give a one-cycle cp_cant in the cycle after the start edge. They change no register and no interrupt line.
- R10: Each line keeps one pending timer. A new schedule replaces a pending one, so the earlier delay never fires.
- R11: A start strobe that arrives while a busy wait is in progress is ignored. It gives no response and has no effect.
- R12: Opcodes 1 to 5 give a one-cycle cp_done in the cycle after the start edge. At most one of cp_busy, cp_done and cp_cant is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_start | input | 1 | One-cycle strobe that starts an operation |
| op_instr | input | 32 | Operation instruction: opcode in 23:20, operand register in 3:0 |
| xfer_wr | input | 1 | Register transfer write enable |
| xfer_instr | input | 32 | Transfer instruction: register index in 19:16 |
| xfer_wdata | input | 32 | Transfer write data |
| xfer_rdata | output | 32 | Transfer read data, combinational from the index |
| fiq_n | output | 1 | Active-low fast interrupt request |
| irq_n | output | 1 | Active-low normal interrupt request |
| cp_busy | output | 1 | Operation still in progress |
| cp_done | output | 1 | Operation completed, one-cycle pulse |
| cp_cant | output | 1 | Operation not supported, one-cycle pulse |

## Verification
The bench goes after the off-by-one edges of the waits. A zero-delay busy wait that raised busy, or a wait that ended one cycle early or late, shows up as a wrong busy count or a wrong done cycle. The same holds for an injected interrupt that drops one edge early or late. A replaced schedule whose earlier timer still fires would drop the line long before the expected cycle. A busy engine that accepted a stray start would overwrite a guarded register or raise cp_cant. Undefined opcodes must pulse cp_cant and leave the lines alone, and two time stamps must differ by the exact number of edges between them.

// File: rtl/vcop_pkg.sv
package vcop_pkg;
  // instruction field positions
  localparam int OPC_LSB  = 20;
  localparam int OPC_W    = 4;
  localparam int RSEL_LSB = 16;
  localparam int DSEL_LSB = 0;
  localparam int NLINE    = 2;   // index 0: fast line, index 1: normal line

  localparam logic [OPC_W-1:0] OPC_WAIT     = 4'd0;
  localparam logic [OPC_W-1:0] OPC_FAST_SET = 4'd1;
  localparam logic [OPC_W-1:0] OPC_NORM_SET = 4'd2;
  localparam logic [OPC_W-1:0] OPC_FAST_CLR = 4'd3;
  localparam logic [OPC_W-1:0] OPC_NORM_CLR = 4'd4;
  localparam logic [OPC_W-1:0] OPC_STAMP    = 4'd5;

  typedef enum logic [1:0] {
    RSP_IDLE,
    RSP_BUSY,
    RSP_DONE,
    RSP_CANT
  } rsp_e;
endpackage

// File: rtl/vcop_regfile.sv
module vcop_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 16,
  parameter int IW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          cap_en,
  input  logic [IW-1:0] cap_idx,
  input  logic [DW-1:0] cap_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  input  logic [IW-1:0] dly_idx,
  output logic [DW-1:0] dly_data
);
  logic [DW-1:0] regs_q [NREG];
  logic [DW-1:0] regs_d [NREG];
  logic [NREG-1:0] ld;

  // next-state: a capture takes precedence over a transfer to the same slot
  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      ld[i]     = 1'b0;
      regs_d[i] = regs_q[i];
      if (cap_en && (cap_idx == IW'(i))) begin
        ld[i]     = 1'b1;
        regs_d[i] = cap_data;
      end else if (wr_en && (wr_idx == IW'(i))) begin
        ld[i]     = 1'b1;
        regs_d[i] = wr_data;
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     regs_q[g] <= '0;
      else if (ld[g]) regs_q[g] <= regs_d[g];
    end
  end

  assign rd_data  = regs_q[rd_idx];
  assign dly_data = regs_q[dly_idx];

  assert_wr_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(cap_en && cap_idx == wr_idx)) |=> (regs_q[$past(wr_idx)] == $past(wr_data)));

  assert_stamp_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (regs_q[$past(cap_idx)] == $past(cap_data)));
endmodule

// File: rtl/vcop_int_timer.sv
module vcop_int_timer #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sched,
  input  logic [CW-1:0] sched_dly,
  input  logic          rel,
  output logic          line_n
);
  logic          pend_q, pend_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          low_q, low_d;
  logic          fire;

  assign fire = pend_q && (cnt_q == CW'(1));

  always_comb begin
    pend_d = pend_q;
    cnt_d  = cnt_q;
    low_d  = low_q;
    if (pend_q) begin
      cnt_d = cnt_q - CW'(1);
      if (fire) pend_d = 1'b0;
    end
    if (fire)     low_d = 1'b1;
    else if (rel) low_d = 1'b0;
    if (sched) begin
      if (sched_dly == '0) begin
        low_d  = 1'b1;
        pend_d = 1'b0;       // an immediate request drops any pending one
      end else begin
        pend_d = 1'b1;       // replaces any earlier pending delay
        cnt_d  = sched_dly;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      low_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      low_q  <= low_d;
      if (pend_q || sched) cnt_q <= cnt_d;
    end
  end

  assign line_n = ~low_q;

  assert_timer_fires_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && cnt_q == CW'(1)) |=> !line_n);

  assert_zero_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sched && sched_dly == '0) |=> !line_n);

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rel && !sched && !(pend_q && cnt_q == CW'(1))) |=> line_n);
endmodule

// File: rtl/vcop_seq.sv
module vcop_seq
  import vcop_pkg::*;
#(
  parameter int DW = 32,
  parameter int IW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_start,
  input  logic [DW-1:0]    op_instr,
  input  logic [DW-1:0]    now,
  output logic [IW-1:0]    dly_idx,
  input  logic [DW-1:0]    dly_data,
  output logic             cap_en,
  output logic [IW-1:0]    cap_idx,
  output logic [DW-1:0]    cap_data,
  output logic [NLINE-1:0] sched_vec,
  output logic [NLINE-1:0] rel_vec,
  output logic [DW-1:0]    sched_dly,
  output logic             busy,
  output logic             done,
  output logic             cant
);
  logic          wait_q, wait_d;
  logic [DW-1:0] fin_q, fin_d;
  logic          fin_en;
  rsp_e          rsp_q, rsp_d;
  logic          accept;
  logic [OPC_W-1:0] opc;
  logic [DW-1:0] gap;
  logic          reached;

  assign opc       = op_instr[OPC_LSB +: OPC_W];
  assign dly_idx   = op_instr[DSEL_LSB +: IW];
  assign cap_idx   = op_instr[DSEL_LSB +: IW];
  assign cap_data  = now;
  assign sched_dly = dly_data;
  assign accept    = op_start && !wait_q;

  // wrap-safe: the wait is over once now - finish is non-negative
  assign gap     = now - fin_q;
  assign reached = ~gap[DW-1];

  always_comb begin
    wait_d    = wait_q;
    fin_d     = fin_q;
    fin_en    = 1'b0;
    rsp_d     = RSP_IDLE;
    cap_en    = 1'b0;
    sched_vec = '0;
    rel_vec   = '0;
    if (accept) begin
      rsp_d = RSP_DONE;
      case (opc)
        OPC_WAIT: begin
          if (dly_data != '0) begin
            wait_d = 1'b1;
            fin_d  = now + dly_data;
            fin_en = 1'b1;
            rsp_d  = RSP_BUSY;
          end
        end
        OPC_FAST_SET: sched_vec[0] = 1'b1;
        OPC_NORM_SET: sched_vec[1] = 1'b1;
        OPC_FAST_CLR: rel_vec[0]   = 1'b1;
        OPC_NORM_CLR: rel_vec[1]   = 1'b1;
        OPC_STAMP:    cap_en       = 1'b1;
        default:      rsp_d        = RSP_CANT;
      endcase
    end else if (wait_q) begin
      if (reached) begin
        wait_d = 1'b0;
        rsp_d  = RSP_DONE;
      end else begin
        rsp_d  = RSP_BUSY;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
      fin_q  <= '0;
      rsp_q  <= RSP_IDLE;
    end else begin
      wait_q <= wait_d;
      rsp_q  <= rsp_d;
      if (fin_en) fin_q <= fin_d;
    end
  end

  assign busy = (rsp_q == RSP_BUSY);
  assign done = (rsp_q == RSP_DONE);
  assign cant = (rsp_q == RSP_CANT);

  assert_one_response_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, done, cant}));

  assert_busy_ends_in_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  assert_cant_follows_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cant |-> $past(op_start));

  assert_busy_blocks_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && op_start) |-> (!cap_en && sched_vec == '0 && rel_vec == '0));
endmodule

// File: rtl/valid_coproc.sv
module valid_coproc
  import vcop_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_start,
  input  logic [DW-1:0] op_instr,
  input  logic          xfer_wr,
  input  logic [DW-1:0] xfer_instr,
  input  logic [DW-1:0] xfer_wdata,
  output logic [DW-1:0] xfer_rdata,
  output logic          fiq_n,
  output logic          irq_n,
  output logic          cp_busy,
  output logic          cp_done,
  output logic          cp_cant
);
  localparam int IW = $clog2(NREG);

  // reset: asserted at once, released after two edges
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // free-running, wrapping cycle counter
  logic [DW-1:0] cyc_q, cyc_d;
  assign cyc_d = cyc_q + DW'(1);
  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) cyc_q <= '0;
    else             cyc_q <= cyc_d;
  end

  logic [IW-1:0]    dly_idx, cap_idx;
  logic [DW-1:0]    dly_data, cap_data, sched_dly;
  logic             cap_en;
  logic [NLINE-1:0] sched_vec, rel_vec, line_n_vec;

  vcop_regfile #(.DW(DW), .NREG(NREG), .IW(IW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .wr_en    (xfer_wr),
    .wr_idx   (xfer_instr[RSEL_LSB +: IW]),
    .wr_data  (xfer_wdata),
    .cap_en   (cap_en),
    .cap_idx  (cap_idx),
    .cap_data (cap_data),
    .rd_idx   (xfer_instr[RSEL_LSB +: IW]),
    .rd_data  (xfer_rdata),
    .dly_idx  (dly_idx),
    .dly_data (dly_data)
  );

  vcop_seq #(.DW(DW), .IW(IW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .op_start  (op_start),
    .op_instr  (op_instr),
    .now       (cyc_q),
    .dly_idx   (dly_idx),
    .dly_data  (dly_data),
    .cap_en    (cap_en),
    .cap_idx   (cap_idx),
    .cap_data  (cap_data),
    .sched_vec (sched_vec),
    .rel_vec   (rel_vec),
    .sched_dly (sched_dly),
    .busy      (cp_busy),
    .done      (cp_done),
    .cant      (cp_cant)
  );

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    vcop_int_timer #(.CW(DW)) u_tmr (
      .clk       (clk),
      .rst_n     (rst_sync_q),
      .sched     (sched_vec[g]),
      .sched_dly (sched_dly),
      .rel       (rel_vec[g]),
      .line_n    (line_n_vec[g])
    );
  end

  assign fiq_n = line_n_vec[0];
  assign irq_n = line_n_vec[1];
endmodule

// File: tb/tb_valid_coproc.sv
module tb_valid_coproc;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_start;
  logic [31:0] op_instr;
  logic        xfer_wr;
  logic [31:0] xfer_instr;
  logic [31:0] xfer_wdata;
  logic [31:0] xfer_rdata;
  logic        fiq_n, irq_n, cp_busy, cp_done, cp_cant;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] model [16];

  always #2 clk = ~clk;   // 4 ns period, 250 MHz

  valid_coproc dut (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_instr(op_instr),
    .xfer_wr(xfer_wr), .xfer_instr(xfer_instr), .xfer_wdata(xfer_wdata),
    .xfer_rdata(xfer_rdata), .fiq_n(fiq_n), .irq_n(irq_n),
    .cp_busy(cp_busy), .cp_done(cp_done), .cp_cant(cp_cant)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_op(input int opc, input int dsel);
    return (32'(opc) << 20) | 32'(dsel);
  endfunction

  task automatic wr_reg(input int idx, input logic [31:0] data);
    @(negedge clk);
    xfer_wr = 1'b1; xfer_instr = 32'(idx) << 16; xfer_wdata = data;
    @(negedge clk);
    xfer_wr = 1'b0;
    model[idx] = data;
  endtask

  // combinational read, at the current negedge
  task automatic rd_reg(input int idx, output logic [31:0] val);
    xfer_instr = 32'(idx) << 16;
    #1 val = xfer_rdata;
  endtask

  // returns at the negedge that follows the start edge (sample 1)
  task automatic start_op(input int opc, input int dsel);
    @(negedge clk);
    op_start = 1'b1; op_instr = mk_op(opc, dsel);
    @(negedge clk);
    op_start = 1'b0;
  endtask

  task automatic run_wait(input int d);
    int busy_n = 0;
    int done_at = 0;
    wr_reg(3, 32'(d));
    start_op(0, 3);
    for (int j = 1; j <= d + 3; j++) begin
      if (cp_busy) busy_n++;
      if (cp_done && done_at == 0) done_at = j;
      @(negedge clk);
    end
    if (d == 0) begin
      check("R3 busy cycles", 32'(busy_n), 32'd0);
      check("R3 done cycle", 32'(done_at), 32'd1);
    end else begin
      check("R4 busy cycles", 32'(busy_n), 32'(d));
      check("R4 done cycle", 32'(done_at), 32'(d + 1));
    end
  endtask

  task automatic run_int(input int line, input int d);
    int low_at = 0;
    logic other_ok = 1'b1;
    wr_reg(5, 32'(d));
    start_op(line == 0 ? 1 : 2, 5);
    check("R12 set done", {31'd0, cp_done}, 32'd1);
    for (int j = 1; j <= d + 3; j++) begin
      if ((line == 0 ? fiq_n : irq_n) == 1'b0 && low_at == 0) low_at = j;
      if ((line == 0 ? irq_n : fiq_n) == 1'b0) other_ok = 1'b0;
      @(negedge clk);
    end
    if (line == 0) check("R5 fiq low cycle", 32'(low_at), 32'(d + 1));
    else           check("R6 irq low cycle", 32'(low_at), 32'(d + 1));
    check("R6 other line untouched", {31'd0, other_ok}, 32'd1);
    start_op(line == 0 ? 3 : 4, 0);
    check("R7 released", {31'd0, (line == 0 ? fiq_n : irq_n)}, 32'd1);
    check("R12 release done", {31'd0, cp_done}, 32'd1);
  endtask

  initial begin
    logic [31:0] v, v2;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; op_start = 1'b0; op_instr = '0;
    xfer_wr = 1'b0; xfer_instr = '0; xfer_wdata = '0;
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 fiq_n", {31'd0, fiq_n}, 32'd1);
    check("R1 irq_n", {31'd0, irq_n}, 32'd1);
    check("R1 handshake", {29'd0, cp_busy, cp_done, cp_cant}, 32'd0);
    for (int i = 0; i < 16; i++) begin
      rd_reg(i, v);
      check("R1 register zero", v, 32'd0);
    end

    // R2 random transfers against the model
    for (int n = 0; n < 40; n++) begin
      int wi = int'($urandom_range(15, 0));
      int ri = int'($urandom_range(15, 0));
      wr_reg(wi, $urandom());
      rd_reg(ri, v);
      check("R2 readback", v, model[ri]);
    end

    // R3/R4 directed corners then random delays
    run_wait(0);
    run_wait(1);
    run_wait(2);
    for (int n = 0; n < 6; n++) run_wait(int'($urandom_range(20, 0)));

    // R5/R6/R7 interrupt injection
    run_int(0, 0);
    run_int(1, 0);
    run_int(0, 1);
    for (int n = 0; n < 6; n++) run_int(n % 2, int'($urandom_range(15, 1)));

    // R8 two captures k edges apart
    for (int n = 0; n < 3; n++) begin
      int k = int'($urandom_range(12, 0));
      start_op(5, 7);
      check("R12 stamp done", {31'd0, cp_done}, 32'd1);
      rd_reg(7, v);
      repeat (k) @(negedge clk);
      start_op(5, 8);
      rd_reg(8, v2);
      check("R8 capture difference", v2 - v, 32'(k + 2));
    end

    // R9 undefined opcodes
    for (int n = 0; n < 5; n++) begin
      int opc = int'($urandom_range(15, 6));
      wr_reg(9, 32'h5A5A_0000 + 32'(n));
      start_op(opc, 9);
      check("R9 cant pulse", {30'd0, cp_cant, cp_done}, 32'd2);
      check("R9 lines untouched", {30'd0, fiq_n, irq_n}, 32'd3);
      rd_reg(9, v);
      check("R9 register untouched", v, 32'h5A5A_0000 + 32'(n));
      @(negedge clk);
      check("R9 cant one cycle", {31'd0, cp_cant}, 32'd0);
    end

    // R10 replacement of a pending schedule
    begin
      int low_at = 0;
      wr_reg(5, 32'd10);
      wr_reg(6, 32'd30);
      start_op(1, 5);
      start_op(1, 6);
      for (int j = 1; j <= 35; j++) begin
        if (!fiq_n && low_at == 0) low_at = j;
        @(negedge clk);
      end
      check("R10 only newer delay fires", 32'(low_at), 32'd31);
      start_op(3, 0);
    end

    // R11 start during busy wait is ignored
    begin
      int cant_n = 0;
      int done_n = 0;
      wr_reg(9, 32'h0000_ABCD);
      wr_reg(3, 32'd12);
      start_op(0, 3);
      start_op(5, 9);
      start_op(7, 9);
      start_op(1, 0);
      for (int j = 0; j < 14; j++) begin
        if (cp_cant) cant_n++;
        if (cp_done) done_n++;
        @(negedge clk);
      end
      rd_reg(9, v);
      check("R11 register kept", v, 32'h0000_ABCD);
      check("R11 no cant", 32'(cant_n), 32'd0);
      check("R11 single done", 32'(done_n), 32'd1);
      check("R11 fiq untouched", {31'd0, fiq_n}, 32'd1);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule